// File: doc/BRIEF.md
# Coprocessor Transfer Handshake Sequencer

This block runs the core side of one coprocessor instruction at a time. An instruction is presented with a one-cycle `start` pulse, together with its kind (load into the coprocessor, store out of the coprocessor, register move to or from the coprocessor, or coprocessor data operation), the coprocessor number, a start address and a writeback flag. The sequencer checks the access permission and the address, then talks to the selected coprocessor by sending a phase code each cycle and reacting to the reply code returned in the same cycle.

While the coprocessor answers "busy", the sequencer alternates an idle cycle with a renewed busy poll. During each idle cycle it samples the interrupt lines and abandons the instruction if one is pending. For loads and stores it drives word-addressed memory requests and moves words between memory and the coprocessor until the coprocessor stops answering "increment". The instruction ends with a one-cycle `done` pulse, on which the status outputs (undefined instruction, abort, interrupted with its cause) and the move result are valid.

Top module: `cop_xfer_seq`

## Requirements
- R1: When bit `copNum` of `accessMask` is clear, `done` rises in the cycle after `start` with `undefInstr` set, and no phase other than NONE is ever sent for that instruction.
- R2: Phase codes are NONE=0, FIRST=1, BUSY=2, INTERRUPT=3, TRANSFER=4, DATA=5; reply codes are ACCEPT=0, BUSY=1, CANT=2, INC=3 (other values act as ACCEPT). The first phase sent is FIRST; each BUSY reply to FIRST or BUSY is followed by exactly one cycle of phase NONE and then a BUSY phase.
- R3: If an interrupt is pending in an idle cycle, the next cycle sends INTERRUPT and the cycle after that raises `done` with `interrupted` set, no undefined-instruction, no abort and no memory access.
- R4: Pending interrupt is decided by priority: `resetReq` first (cause 1), then `fiqReq` when `fiqMask` is clear (cause 2), then `irqReq` when `irqMask` is clear (cause 3); a masked request has no effect and the busy poll continues.
- R5: Operation codes are LOAD=0, STORE=1, MOVE_TO=2, MOVE_FROM=3, DATA_OP=4. A CANT reply to FIRST or BUSY ends the instruction with `abortOut` for LOAD and STORE and with `undefInstr` for the other kinds.
- R6: For an accepted LOAD, one TRANSFER phase is sent, then DATA phases; in each DATA phase a memory read is made at word address `startAddr[31:2]` plus the count of earlier DATA phases and the word read is presented on `cpWdata`. An INC reply causes another DATA phase; any other reply ends the instruction.
- R7: For an accepted STORE, DATA phases follow the accepting reply directly; in each one `cpRdata` is written to memory at word address `startAddr[31:2]` plus the count of earlier DATA phases, with INC continuing the burst.
- R8: A LOAD or STORE whose address has any of bits 31..26 set, or a STORE whose byte address is below 32, ends with `abortOut` in the cycle after `start` and sends no phase.
- R9: An accepted MOVE_FROM returns on `moveResult` the `cpRdata` of the accepting cycle; a refused one returns `flagsIn` in bits 31..28 and zero elsewhere, so the condition flags are unchanged.
- R10: With `wbBit` set, an accepted LOAD or STORE pulses `wbStrobe` exactly once, in the cycle just before the first DATA phase; otherwise it never pulses.
- R11: During FIRST and BUSY phases of a MOVE_TO, `cpWdata` carries `moveSrc` and `cpSel` carries the coprocessor number.
- R12: After reset the block is idle (phase NONE, no request, `busy` and `done` low); `done` is a single-cycle pulse and `start` has no effect while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction (taken when idle) |
| opKind | input | 3 | Instruction kind |
| copNum | input | 4 | Coprocessor number |
| wbBit | input | 1 | Base writeback requested |
| startAddr | input | 32 | Byte address for load/store |
| moveSrc | input | 32 | Register value for a move to the coprocessor |
| accessMask | input | 16 | Per-coprocessor access permission |
| flagsIn | input | 4 | Current condition flags |
| resetReq | input | 1 | Reset request |
| fiqReq | input | 1 | Fast interrupt request |
| fiqMask | input | 1 | Fast interrupt masked |
| irqReq | input | 1 | Normal interrupt request |
| irqMask | input | 1 | Normal interrupt masked |
| cpPhase | output | 3 | Phase code sent to the coprocessor |
| cpSel | output | 4 | Selected coprocessor |
| cpWdata | output | 32 | Data sent to the coprocessor |
| cpReply | input | 3 | Reply code from the coprocessor |
| cpRdata | input | 32 | Data from the coprocessor |
| memReq | output | 1 | Memory access request |
| memWrite | output | 1 | Memory access is a write |
| memAddr | output | 30 | Memory word address |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data (same cycle) |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Instruction finished (one cycle) |
| undefInstr | output | 1 | Undefined-instruction status |
| abortOut | output | 1 | Abort status |
| interrupted | output | 1 | Instruction abandoned for an interrupt |
| intCause | output | 2 | Interrupt cause code |
| wbStrobe | output | 1 | Base writeback strobe |
| moveResult | output | 32 | Result of a move from the coprocessor |

## Verification
On every cycle the assertions watch the local handshake rules: a busy reply is always followed by an idle cycle, an interrupt phase always ends the instruction, memory is only touched in data phases, the writeback strobe always precedes a data phase, a permission failure finishes at once, and the address steps by one word on each increment. Whole phase sequences, the interrupt priority among combined requests, burst data contents in memory and on the coprocessor bus, and the move results can only be shown by the bench's scenarios, which sweep busy counts, burst lengths and interrupt combinations and compare against sequences built from the requirements.

// File: rtl/cop_xfer_pkg.sv
package cop_xfer_pkg;

  typedef enum logic [2:0] {
    PH_NONE  = 3'd0,
    PH_FIRST = 3'd1,
    PH_BUSY  = 3'd2,
    PH_INTR  = 3'd3,
    PH_XFER  = 3'd4,
    PH_DATA  = 3'd5
  } phase_e;

  localparam logic [2:0] RP_ACCEPT = 3'd0;
  localparam logic [2:0] RP_BUSY   = 3'd1;
  localparam logic [2:0] RP_CANT   = 3'd2;
  localparam logic [2:0] RP_INC    = 3'd3;

  localparam logic [2:0] OP_LOAD      = 3'd0;
  localparam logic [2:0] OP_STORE     = 3'd1;
  localparam logic [2:0] OP_MOVE_TO   = 3'd2;
  localparam logic [2:0] OP_MOVE_FROM = 3'd3;
  localparam logic [2:0] OP_DATA_OP   = 3'd4;

  localparam logic [1:0] CAUSE_NONE  = 2'd0;
  localparam logic [1:0] CAUSE_RESET = 2'd1;
  localparam logic [1:0] CAUSE_FIQ   = 2'd2;
  localparam logic [1:0] CAUSE_IRQ   = 2'd3;

  typedef struct packed {
    logic latchInstr;
    logic incAddr;
    logic takeResult;
    logic takeRefused;
  } dpCtl_t;

endpackage

// File: rtl/cop_xfer_dp.sv
module cop_xfer_dp
  import cop_xfer_pkg::*;
#(
  parameter int NUM_CP          = 16,
  parameter int ADDR_W          = 32,
  parameter int DATA_W          = 32,
  parameter int FLAG_W          = 4,
  parameter int ADDR_LIMIT_BITS = 26,
  parameter int VEC_BYTES       = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dpCtl_t                    ctl,
  input  logic [2:0]                opKind,
  input  logic [$clog2(NUM_CP)-1:0] copNum,
  input  logic                      wbBit,
  input  logic [ADDR_W-1:0]         startAddr,
  input  logic [DATA_W-1:0]         moveSrc,
  input  logic [NUM_CP-1:0]         accessMask,
  input  logic [FLAG_W-1:0]         flagsIn,
  input  logic [DATA_W-1:0]         cpRdata,
  input  logic [DATA_W-1:0]         memRdata,
  output logic                      permOk,
  output logic                      addrExc,
  output logic [2:0]                opR,
  output logic                      wbR,
  output logic [$clog2(NUM_CP)-1:0] cpSel,
  output logic [ADDR_W-3:0]         memAddr,
  output logic [DATA_W-1:0]         cpWdata,
  output logic [DATA_W-1:0]         memWdata,
  output logic [DATA_W-1:0]         moveResult
);

  localparam int CPN_W   = $clog2(NUM_CP);
  localparam int WA_W    = ADDR_W - 2;
  localparam int RES_PAD = DATA_W - FLAG_W;

  logic [CPN_W-1:0]  copR;
  logic [WA_W-1:0]   wordAddr;
  logic [DATA_W-1:0] moveSrcR;
  logic [DATA_W-1:0] resultR;
  logic              hiBits;
  logic              isLdStIn;
  logic              inVector;

  // Address checks on the raw instruction fields, used in the start cycle.
  generate
    if (ADDR_LIMIT_BITS < ADDR_W) begin : g_limit
      assign hiBits = |startAddr[ADDR_W-1:ADDR_LIMIT_BITS];
    end else begin : g_nolimit
      assign hiBits = 1'b0;
    end
  endgenerate

  assign isLdStIn = (opKind == OP_LOAD) || (opKind == OP_STORE);
  assign inVector = (opKind == OP_STORE) && (startAddr < ADDR_W'(VEC_BYTES));
  assign addrExc  = isLdStIn && (hiBits || inVector);
  assign permOk   = accessMask[copNum];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opR      <= OP_DATA_OP;
      wbR      <= 1'b0;
      copR     <= '0;
      wordAddr <= '0;
      moveSrcR <= '0;
      resultR  <= '0;
    end else begin
      if (ctl.latchInstr) begin
        opR      <= opKind;
        wbR      <= wbBit;
        copR     <= copNum;
        wordAddr <= startAddr[ADDR_W-1:2];
        moveSrcR <= moveSrc;
      end else if (ctl.incAddr) begin
        wordAddr <= wordAddr + WA_W'(1);
      end
      if (ctl.takeResult) begin
        resultR <= cpRdata;
      end else if (ctl.takeRefused) begin
        resultR <= {flagsIn, {RES_PAD{1'b0}}};
      end
    end
  end

  assign cpSel      = copR;
  assign memAddr    = wordAddr;
  assign cpWdata    = (opR == OP_LOAD) ? memRdata : moveSrcR;
  assign memWdata   = cpRdata;
  assign moveResult = resultR;

  // R6 R7
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.incAddr |=> (memAddr == $past(memAddr) + WA_W'(1)));

endmodule

// File: rtl/cop_xfer_ctrl.sv
module cop_xfer_ctrl
  import cop_xfer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       permOk,
  input  logic       addrExc,
  input  logic [2:0] opR,
  input  logic       wbR,
  input  logic [2:0] cpReply,
  input  logic       resetReq,
  input  logic       fiqReq,
  input  logic       fiqMask,
  input  logic       irqReq,
  input  logic       irqMask,
  output phase_e     phase,
  output logic       memReq,
  output logic       memWrite,
  output logic       wbStrobe,
  output logic       busy,
  output logic       done,
  output logic       undefInstr,
  output logic       abortOut,
  output logic       interrupted,
  output logic [1:0] intCause,
  output dpCtl_t     ctl
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ASK, ST_WAIT, ST_POLL, ST_INTR, ST_XFER, ST_LDATA, ST_SDATA
  } state_e;

  state_e     state, nxt;
  logic       finR;
  logic       finNext;
  logic       setUndef, setAbort, setIntr;
  logic       isLoad, isStore, isLdSt, isMoveFrom;
  logic [1:0] causeNow;
  logic       intPending;
  logic       undefR, abortR, intrR;
  logic [1:0] causeR;
  logic       idleStart;

  assign isLoad     = (opR == OP_LOAD);
  assign isStore    = (opR == OP_STORE);
  assign isLdSt     = isLoad || isStore;
  assign isMoveFrom = (opR == OP_MOVE_FROM);
  assign idleStart  = (state == ST_IDLE) && !finR && start;

  // Interrupt priority: reset, then unmasked fast, then unmasked normal.
  always_comb begin
    if (resetReq)                causeNow = CAUSE_RESET;
    else if (fiqReq && !fiqMask) causeNow = CAUSE_FIQ;
    else if (irqReq && !irqMask) causeNow = CAUSE_IRQ;
    else                         causeNow = CAUSE_NONE;
  end
  assign intPending = (causeNow != CAUSE_NONE);

  always_comb begin
    nxt      = state;
    finNext  = 1'b0;
    phase    = PH_NONE;
    memReq   = 1'b0;
    memWrite = 1'b0;
    wbStrobe = 1'b0;
    setUndef = 1'b0;
    setAbort = 1'b0;
    setIntr  = 1'b0;
    ctl      = '0;
    case (state)
      ST_IDLE: begin
        if (idleStart) begin
          ctl.latchInstr = 1'b1;
          if (!permOk) begin
            setUndef = 1'b1;
            finNext  = 1'b1;
          end else if (addrExc) begin
            setAbort = 1'b1;
            finNext  = 1'b1;
          end else begin
            nxt = ST_ASK;
          end
        end
      end
      ST_ASK, ST_POLL: begin
        phase = (state == ST_ASK) ? PH_FIRST : PH_BUSY;
        if (cpReply == RP_BUSY) begin
          nxt = ST_WAIT;
        end else if (cpReply == RP_CANT) begin
          nxt             = ST_IDLE;
          finNext         = 1'b1;
          setAbort        = isLdSt;
          setUndef        = !isLdSt;
          ctl.takeRefused = isMoveFrom;
        end else if (isLoad) begin
          nxt = ST_XFER;
        end else if (isStore) begin
          nxt      = ST_SDATA;
          wbStrobe = wbR;
        end else begin
          nxt            = ST_IDLE;
          finNext        = 1'b1;
          ctl.takeResult = isMoveFrom;
        end
      end
      ST_WAIT: begin
        nxt = intPending ? ST_INTR : ST_POLL;
      end
      ST_INTR: begin
        phase   = PH_INTR;
        nxt     = ST_IDLE;
        finNext = 1'b1;
        setIntr = 1'b1;
      end
      ST_XFER: begin
        phase    = PH_XFER;
        wbStrobe = wbR;
        nxt      = ST_LDATA;
      end
      ST_LDATA, ST_SDATA: begin
        phase    = PH_DATA;
        memReq   = 1'b1;
        memWrite = (state == ST_SDATA);
        if (cpReply == RP_INC) begin
          ctl.incAddr = 1'b1;
        end else begin
          nxt     = ST_IDLE;
          finNext = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      finR   <= 1'b0;
      undefR <= 1'b0;
      abortR <= 1'b0;
      intrR  <= 1'b0;
      causeR <= CAUSE_NONE;
    end else begin
      state <= nxt;
      finR  <= finNext;
      if (idleStart) begin
        undefR <= 1'b0;
        abortR <= 1'b0;
        intrR  <= 1'b0;
        causeR <= CAUSE_NONE;
      end
      if (setUndef) undefR <= 1'b1;
      if (setAbort) abortR <= 1'b1;
      if (setIntr)  intrR  <= 1'b1;
      if (state == ST_WAIT && intPending) causeR <= causeNow;
    end
  end

  assign busy        = (state != ST_IDLE) || finR;
  assign done        = finR;
  assign undefInstr  = undefR;
  assign abortOut    = abortR;
  assign interrupted = intrR;
  assign intCause    = causeR;

  // R1
  deny_chk: assert property (@(posedge clk) disable iff (!rstN)
    (idleStart && !permOk) |=> (done && undefInstr && phase == PH_NONE));

  // R2
  busy_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((phase == PH_FIRST || phase == PH_BUSY) && cpReply == RP_BUSY)
      |=> (phase == PH_NONE && !done));

  // R3
  intr_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_INTR) |=> (done && interrupted && !undefInstr && !abortOut));

  // R6 R7
  mem_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (phase == PH_DATA));

  // R10
  wb_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbStrobe |=> (phase == PH_DATA));

endmodule

// File: rtl/cop_xfer_seq.sv
module cop_xfer_seq
  import cop_xfer_pkg::*;
#(
  parameter int NUM_CP          = 16,
  parameter int ADDR_W          = 32,
  parameter int DATA_W          = 32,
  parameter int FLAG_W          = 4,
  parameter int ADDR_LIMIT_BITS = 26,
  parameter int VEC_BYTES       = 32,
  localparam int CPN_W          = $clog2(NUM_CP)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        opKind,
  input  logic [CPN_W-1:0]  copNum,
  input  logic              wbBit,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [DATA_W-1:0] moveSrc,
  input  logic [NUM_CP-1:0] accessMask,
  input  logic [FLAG_W-1:0] flagsIn,
  input  logic              resetReq,
  input  logic              fiqReq,
  input  logic              fiqMask,
  input  logic              irqReq,
  input  logic              irqMask,
  output logic [2:0]        cpPhase,
  output logic [CPN_W-1:0]  cpSel,
  output logic [DATA_W-1:0] cpWdata,
  input  logic [2:0]        cpReply,
  input  logic [DATA_W-1:0] cpRdata,
  output logic              memReq,
  output logic              memWrite,
  output logic [ADDR_W-3:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              busy,
  output logic              done,
  output logic              undefInstr,
  output logic              abortOut,
  output logic              interrupted,
  output logic [1:0]        intCause,
  output logic              wbStrobe,
  output logic [DATA_W-1:0] moveResult
);

  dpCtl_t     ctl;
  phase_e     phase;
  logic       permOk;
  logic       addrExc;
  logic [2:0] opR;
  logic       wbR;

  cop_xfer_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .permOk     (permOk),
    .addrExc    (addrExc),
    .opR        (opR),
    .wbR        (wbR),
    .cpReply    (cpReply),
    .resetReq   (resetReq),
    .fiqReq     (fiqReq),
    .fiqMask    (fiqMask),
    .irqReq     (irqReq),
    .irqMask    (irqMask),
    .phase      (phase),
    .memReq     (memReq),
    .memWrite   (memWrite),
    .wbStrobe   (wbStrobe),
    .busy       (busy),
    .done       (done),
    .undefInstr (undefInstr),
    .abortOut   (abortOut),
    .interrupted(interrupted),
    .intCause   (intCause),
    .ctl        (ctl)
  );

  cop_xfer_dp #(
    .NUM_CP         (NUM_CP),
    .ADDR_W         (ADDR_W),
    .DATA_W         (DATA_W),
    .FLAG_W         (FLAG_W),
    .ADDR_LIMIT_BITS(ADDR_LIMIT_BITS),
    .VEC_BYTES      (VEC_BYTES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .opKind    (opKind),
    .copNum    (copNum),
    .wbBit     (wbBit),
    .startAddr (startAddr),
    .moveSrc   (moveSrc),
    .accessMask(accessMask),
    .flagsIn   (flagsIn),
    .cpRdata   (cpRdata),
    .memRdata  (memRdata),
    .permOk    (permOk),
    .addrExc   (addrExc),
    .opR       (opR),
    .wbR       (wbR),
    .cpSel     (cpSel),
    .memAddr   (memAddr),
    .cpWdata   (cpWdata),
    .memWdata  (memWdata),
    .moveResult(moveResult)
  );

  assign cpPhase = phase;

endmodule

// File: tb/cop_xfer_seq_tb.sv
`timescale 1ns/1ps
module cop_xfer_seq_tb;

  localparam logic [31:0] STORE_TAG = 32'hC0DE_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  opKind = 3'd0;
  logic [3:0]  copNum = 4'd0;
  logic        wbBit = 1'b0;
  logic [31:0] startAddr = 32'd0;
  logic [31:0] moveSrc = 32'd0;
  logic [15:0] accessMask = 16'hFFFF;
  logic [3:0]  flagsIn = 4'd0;
  logic        resetReq = 1'b0, fiqReq = 1'b0, fiqMask = 1'b0;
  logic        irqReq = 1'b0, irqMask = 1'b0;
  logic [2:0]  cpPhase;
  logic [3:0]  cpSel;
  logic [31:0] cpWdata;
  logic [2:0]  cpReply;
  logic [31:0] cpRdata;
  logic        memReq, memWrite;
  logic [29:0] memAddr;
  logic [31:0] memWdata, memRdata;
  logic        busy, done, undefInstr, abortOut, interrupted, wbStrobe;
  logic [1:0]  intCause;
  logic [31:0] moveResult;

  int checks = 0;
  int errors = 0;

  // coprocessor model configuration and state
  int          mBusyN = 0;
  int          mIncN = 0;
  logic [2:0]  mFinal = 3'd0;
  logic [31:0] moveVal = 32'd0;
  int          busySeen = 0;
  int          dataSeen = 0;

  logic [31:0] mem [64];

  // log of one instruction
  logic [2:0]  lgPh [64];
  logic        lgReq [64];
  logic        lgWr [64];
  logic [29:0] lgAddr [64];
  logic [31:0] lgWd [64];
  logic        lgWb [64];
  logic [3:0]  lgSel [64];
  int          logN = 0;

  always #2.5 clk = ~clk;

  cop_xfer_seq u_dut (
    .clk(clk), .rstN(rstN), .start(start), .opKind(opKind), .copNum(copNum),
    .wbBit(wbBit), .startAddr(startAddr), .moveSrc(moveSrc),
    .accessMask(accessMask), .flagsIn(flagsIn), .resetReq(resetReq),
    .fiqReq(fiqReq), .fiqMask(fiqMask), .irqReq(irqReq), .irqMask(irqMask),
    .cpPhase(cpPhase), .cpSel(cpSel), .cpWdata(cpWdata), .cpReply(cpReply),
    .cpRdata(cpRdata), .memReq(memReq), .memWrite(memWrite),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .busy(busy), .done(done), .undefInstr(undefInstr), .abortOut(abortOut),
    .interrupted(interrupted), .intCause(intCause), .wbStrobe(wbStrobe),
    .moveResult(moveResult)
  );

  function automatic logic [31:0] memVal(input int i);
    return (32'(i) * 32'h0100_0193) ^ 32'h5A5A_0000;
  endfunction

  // coprocessor model: replies in the same cycle as the phase
  always_comb begin
    cpReply = 3'd0;
    if (cpPhase == 3'd1 || cpPhase == 3'd2)
      cpReply = (busySeen < mBusyN) ? 3'd1 : mFinal;
    else if (cpPhase == 3'd5)
      cpReply = (dataSeen < mIncN) ? 3'd3 : 3'd0;
    cpRdata = (cpPhase == 3'd5) ? (STORE_TAG + 32'(dataSeen)) : moveVal;
  end

  always @(posedge clk) begin
    if (start && !busy) begin
      busySeen <= 0;
      dataSeen <= 0;
    end else begin
      if (cpPhase == 3'd1 || cpPhase == 3'd2) busySeen <= busySeen + 1;
      if (cpPhase == 3'd5) dataSeen <= dataSeen + 1;
    end
  end

  // memory model
  assign memRdata = mem[memAddr[5:0]];
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 64; i++) mem[i] <= memVal(i);
    end else if (memReq && memWrite) begin
      mem[memAddr[5:0]] <= memWdata;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic runOp(input logic [2:0] op, input int cop, input logic [31:0] addr,
                       input bit wb, input int busyN, input logic [2:0] fin,
                       input int incN, input bit holdStart, input string tag);
    int expPh [64];
    int expLen;
    int cyc;
    int badIdx;
    int cause;
    int firstData;
    int wbCount;
    int wbIdx;
    int dj;
    bit pend, den, aexc, ldst, eU, eA, eI, accepted;
    // expected behaviour from the requirements
    ldst = (op == 3'd0) || (op == 3'd1);
    den  = !accessMask[cop];
    aexc = ldst && ((addr[31:26] != 6'd0) || (op == 3'd1 && addr < 32));
    cause = resetReq ? 1 : (fiqReq && !fiqMask) ? 2 : (irqReq && !irqMask) ? 3 : 0;
    pend = (cause != 0);
    eU = 0; eA = 0; eI = 0; accepted = 0; expLen = 0;
    if (den) eU = 1;
    else if (aexc) eA = 1;
    else begin
      expPh[expLen++] = 1;
      for (int b = 0; b < busyN; b++) begin
        expPh[expLen++] = 0;
        if (pend) begin expPh[expLen++] = 3; eI = 1; break; end
        expPh[expLen++] = 2;
      end
      if (!eI) begin
        if (fin == 3'd2) begin
          if (ldst) eA = 1; else eU = 1;
        end else begin
          accepted = 1;
          if (op == 3'd0) expPh[expLen++] = 4;
          if (ldst) for (int d = 0; d <= incN; d++) expPh[expLen++] = 5;
        end
      end
    end

    @(negedge clk);
    opKind = op; copNum = 4'(cop); startAddr = addr; wbBit = wb;
    mBusyN = busyN; mIncN = incN; mFinal = fin;
    start = 1'b1;
    logN = 0;
    cyc = 0;
    @(negedge clk);
    if (!holdStart) start = 1'b0;
    while (!done && cyc < 300) begin
      if (logN < 64) begin
        lgPh[logN] = cpPhase; lgReq[logN] = memReq; lgWr[logN] = memWrite;
        lgAddr[logN] = memAddr; lgWd[logN] = cpWdata; lgWb[logN] = wbStrobe;
        lgSel[logN] = cpSel;
        logN++;
      end
      cyc++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(cyc < 300, "R12", {tag, " done reached"}, 32'(cyc), 32'd300);

    // phase sequence
    badIdx = -1;
    for (int k = 0; k < expLen && k < logN; k++)
      if (badIdx < 0 && int'(lgPh[k]) != expPh[k]) badIdx = k;
    chk(logN == expLen, tag, "phase count", 32'(logN), 32'(expLen));
    chk(badIdx < 0, tag, "first wrong phase index", 32'(badIdx), 32'hFFFF_FFFF);

    // status on the done cycle
    chk({undefInstr, abortOut, interrupted} == {eU, eA, eI}, tag,
        "undef/abort/interrupted", {29'd0, undefInstr, abortOut, interrupted},
        {29'd0, eU, eA, eI});
    if (eI) chk(intCause == 2'(cause), "R4", "interrupt cause",
                32'(intCause), 32'(cause));

    // memory traffic
    dj = 0; firstData = -1; wbCount = 0; wbIdx = -1;
    for (int k = 0; k < logN; k++) begin
      if (lgWb[k]) begin wbCount++; wbIdx = k; end
      if (lgReq[k]) begin
        if (firstData < 0) firstData = k;
        chk(lgAddr[k] == addr[31:2] + 30'(dj), op == 3'd0 ? "R6" : "R7",
            "word address", 32'(lgAddr[k]), 32'(addr[31:2] + 30'(dj)));
        chk(lgWr[k] == (op == 3'd1), op == 3'd0 ? "R6" : "R7", "write flag",
            32'(lgWr[k]), 32'(op == 3'd1));
        if (op == 3'd0)
          chk(lgWd[k] == memVal(int'(addr[7:2]) + dj), "R6", "word to coprocessor",
              lgWd[k], memVal(int'(addr[7:2]) + dj));
        dj++;
      end
      if (op == 3'd2 && (lgPh[k] == 3'd1 || lgPh[k] == 3'd2)) begin
        chk(lgWd[k] == moveSrc, "R11", "move source on bus", lgWd[k], moveSrc);
        chk(lgSel[k] == 4'(cop), "R11", "selected coprocessor", 32'(lgSel[k]), 32'(cop));
      end
    end
    if (eI) chk(dj == 0, "R3", "no memory access", 32'(dj), 32'd0);
    if (op == 3'd1 && accepted)
      for (int d = 0; d <= incN; d++)
        chk(mem[int'(addr[7:2]) + d] == STORE_TAG + 32'(d), "R7", "stored word",
            mem[int'(addr[7:2]) + d], STORE_TAG + 32'(d));
    chk(wbCount == ((wb && accepted && ldst) ? 1 : 0), "R10", "strobe count",
        32'(wbCount), 32'((wb && accepted && ldst) ? 1 : 0));
    if (wbCount == 1)
      chk(wbIdx == firstData - 1, "R10", "strobe position", 32'(wbIdx), 32'(firstData - 1));
    if (op == 3'd3 && !eI && !den)
      chk(moveResult == (accepted ? moveVal : {flagsIn, 28'd0}), "R9", "move result",
          moveResult, accepted ? moveVal : {flagsIn, 28'd0});

    // done lasts one cycle
    @(negedge clk);
    chk(!done && !busy, "R12", "done single pulse", {30'd0, done, busy}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog expired: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(cpPhase == 3'd0 && !memReq && !busy && !done, "R12", "idle after reset",
        {27'd0, cpPhase, memReq, busy, done}, 32'd0);

    // R6 R7 R2 R10: load and store sweep
    for (int op = 0; op < 2; op++)
      for (int b = 0; b < 3; b++)
        for (int n = 0; n < 3; n++)
          runOp(3'(op), 2, op == 0 ? 32'h40 : 32'hA0, ((b + n) % 2) == 1, b,
                3'd0, n, 1'b0, op == 0 ? "R6" : "R7");

    // R5 refusal for every kind, R9 refused move keeps flags
    flagsIn = 4'hA;
    moveVal = 32'h1234_5678;
    for (int op = 0; op < 5; op++)
      runOp(3'(op), 3, op == 1 ? 32'hA0 : 32'h40, 1'b1, 1, 3'd2, 0, 1'b0, "R5");

    // R1 permission denied for every kind
    accessMask = 16'hFFDF;
    for (int op = 0; op < 5; op++)
      runOp(3'(op), 5, 32'hA0, 1'b0, 2, 3'd0, 1, 1'b0, "R1");
    accessMask = 16'hFFFF;

    // R3 R4 interrupt combinations during one busy wait
    for (int c = 0; c < 32; c++) begin
      resetReq = c[0]; fiqReq = c[1]; fiqMask = c[2]; irqReq = c[3]; irqMask = c[4];
      runOp(3'd4, 7, 32'h0, 1'b0, 1, 3'd0, 0, 1'b0, "R3");
    end
    resetReq = 0; fiqReq = 0; fiqMask = 0; irqReq = 0; irqMask = 0;

    // R8 address checks and boundaries
    runOp(3'd0, 1, 32'h0400_0040, 1'b1, 0, 3'd0, 0, 1'b0, "R8");
    runOp(3'd0, 1, 32'h8000_0040, 1'b0, 0, 3'd0, 0, 1'b0, "R8");
    runOp(3'd1, 1, 32'h0000_001C, 1'b1, 0, 3'd0, 0, 1'b0, "R8");
    runOp(3'd1, 1, 32'h0000_0020, 1'b0, 0, 3'd0, 1, 1'b0, "R8");
    runOp(3'd0, 1, 32'h0000_0010, 1'b0, 0, 3'd0, 1, 1'b0, "R8");

    // R11 move to coprocessor, R9 accepted move from coprocessor
    moveSrc = 32'hFACE_0B0E;
    runOp(3'd2, 9, 32'h0, 1'b1, 2, 3'd0, 0, 1'b0, "R11");
    moveVal = 32'h8765_4321;
    runOp(3'd3, 15, 32'h0, 1'b0, 1, 3'd0, 0, 1'b0, "R9");
    flagsIn = 4'h5;
    runOp(3'd3, 0, 32'h0, 1'b0, 0, 3'd2, 0, 1'b0, "R9");

    // R12 start held high while busy has no effect
    runOp(3'd1, 4, 32'hB0, 1'b1, 2, 3'd0, 2, 1'b1, "R12");
    runOp(3'd0, 4, 32'h60, 1'b0, 1, 3'd0, 1, 1'b1, "R12");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule